// File: doc/BRIEF.md
# Cached-NTT Transfer Address Generator

This block produces the address streams that move coefficient groups between external DRAM and an on-chip group buffer during a two-epoch cached number theoretic transform. A polynomial of n = 2^LOG_N coefficients, with LOG_N even, is split into G groups of C coefficients, where G = C = 2^(LOG_N/2). The buffer holds K = 2^LOG_K groups at once. Each command covers one batch of K consecutive groups starting at an aligned group index. For every coefficient of the batch it emits one beat carrying a DRAM word address and the matching buffer address. The DRAM side is ordered so that bursts stay as long as the selected permutation allows. The buffer side takes any non-contiguous order the permutation needs.

There are three transfer orders. The linear order copies a contiguous batch as one long burst. The transpose order implements the epoch reordering, which maps index g*C + c to c*G + g. The transpose-with-reversal order also bit-reverses the whole LOG_N-bit index. A sequencer issues commands with a start pulse. It must let all batches of one epoch, including their reordering, finish before it issues any batch of the next epoch.

Top module: `ntt_xfer_agu`

## Requirements
- R1: While reset is asserted and after its release with no start, busy, beatValid, done and burstStart are all 0.
- R2: A start seen while idle raises busy and beatValid on the next cycle. Exactly K*C beats follow on consecutive cycles. In the cycle after the last beat, done is 1 for exactly one cycle with busy and beatValid at 0, and idle follows.
- R3: While a command runs, start and all command inputs (cmdMode, cmdGroup, cmdBase) have no effect on the beat sequence, its length or its end.
- R4: With cmdMode = 0 (linear), beat i (k = i / C, c = i mod C) gives dramAddr = base + (g0 + k)*C + c and bufAddr = i. It forms one burst of length K*C.
- R5: With cmdMode = 1 (transpose), beat i (c = i / K, k = i mod K) gives dramAddr = base + c*G + (g0 + k) and bufAddr = k*C + c. A burst of length K starts every K beats.
- R6: With cmdMode = 2 (transpose with reversal), beat i (k = i / C, j = i mod C) gives dramAddr = base + rev(g0 + k)*C + j and bufAddr = k*C + rev(j). Here rev reverses a LOG_N/2-bit value. A burst of length C starts every C beats.
- R7: cmdMode = 3 behaves exactly as cmdMode = 0.
- R8: The first beat of a command opens a burst. Within a burst, dramAddr rises by one per beat and burstLen stays constant. Each burst holds exactly burstLen beats. burstStart is 1 only on the first beat of each burst. All addresses wrap modulo 2^ADDR_W.
- R9: Running transpose commands for all G/K batches writes every one of the n DRAM words exactly once, and the word at c*G + g receives coefficient g*C + c. The same holds for transpose with reversal, where coefficient g*C + c lands at rev(g)*C + rev(c).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command when idle |
| cmdMode | input | 2 | 0 linear, 1 transpose, 2 transpose with reversal, 3 as linear |
| cmdGroup | input | LOG_N/2 | First group of the batch, a multiple of K |
| cmdBase | input | ADDR_W | DRAM base word address |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse after the last beat |
| beatValid | output | 1 | Addresses valid this cycle |
| dramAddr | output | ADDR_W | DRAM word address of this beat |
| bufAddr | output | LOG_K+LOG_N/2 | Group buffer address of this beat |
| burstStart | output | 1 | First beat of a DRAM burst |
| burstLen | output | LOG_K+LOG_N/2+1 | Length of the current burst in beats |

## Verification
The assertions assume that the command group index is a multiple of K and that reset is held from the first clock. With those inputs, the checks on burst continuity and burst length hold for every mode. The bench draws group indices only as random multiples of K and draws bases over the whole address range, including values near the top that make the addresses wrap. It holds start high with changing command inputs during some commands to exercise R3. A DRAM memory model walks all batches of both reordering modes to check the full permutation.

// File: rtl/ntt_xfer_pkg.sv
package ntt_xfer_pkg;

  typedef enum logic [1:0] {
    XFER_LINEAR        = 2'd0,
    XFER_TRANSPOSE     = 2'd1,
    XFER_TRANSPOSE_REV = 2'd2,
    XFER_SPARE         = 2'd3
  } xferMode_t;

  typedef struct packed {
    logic load;
    logic step;
  } ctrlStrobes_t;

endpackage

// File: rtl/ntt_xfer_ctrl.sv
module ntt_xfer_ctrl
  import ntt_xfer_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         lastBeat,
  output ctrlStrobes_t strobes,
  output logic         busy,
  output logic         beatValid,
  output logic         done
);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } ctrlState_t;

  ctrlState_t stateQ, stateD;

  always_comb begin
    stateD  = stateQ;
    strobes = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strobes.load = 1'b1;
          stateD       = ST_RUN;
        end
      end
      ST_RUN: begin
        strobes.step = 1'b1;
        if (lastBeat) stateD = ST_FIN;
      end
      ST_FIN:  stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busy      = (stateQ == ST_RUN);
  assign beatValid = (stateQ == ST_RUN);
  assign done      = (stateQ == ST_FIN);

endmodule

// File: rtl/ntt_xfer_perm.sv
module ntt_xfer_perm
  import ntt_xfer_pkg::*;
#(
  parameter int LOG_N  = 12,
  parameter int LOG_K  = 3,
  parameter int ADDR_W = 32,
  localparam int LOG_C  = LOG_N / 2,
  localparam int LOG_G  = LOG_C,
  localparam int BEAT_W = LOG_K + LOG_C,
  localparam int LEN_W  = BEAT_W + 1
) (
  input  xferMode_t           mode,
  input  logic [BEAT_W-1:0]   cnt,
  input  logic [LOG_G-1:0]    groupBase,
  input  logic [ADDR_W-1:0]   base,
  output logic [ADDR_W-1:0]   dramAddr,
  output logic [BEAT_W-1:0]   bufAddr,
  output logic                burstFirst,
  output logic [LEN_W-1:0]    burstLen
);

  localparam logic [LEN_W-1:0] LEN_ALL   = LEN_W'(1) << BEAT_W;
  localparam logic [LEN_W-1:0] LEN_SLOTS = LEN_W'(1) << LOG_K;
  localparam logic [LEN_W-1:0] LEN_GROUP = LEN_W'(1) << LOG_C;

  // Group-major split: slot in the top bits, coefficient in the low bits.
  logic [LOG_K-1:0] slotMajor;
  logic [LOG_C-1:0] innerMajor;
  // Coefficient-major split: slot in the low bits, coefficient on top.
  logic [LOG_K-1:0] slotMinor;
  logic [LOG_C-1:0] innerMinor;

  assign slotMajor  = cnt[BEAT_W-1 -: LOG_K];
  assign innerMajor = cnt[LOG_C-1:0];
  assign slotMinor  = cnt[LOG_K-1:0];
  assign innerMinor = cnt[BEAT_W-1 -: LOG_C];

  logic [LOG_G-1:0] groupMajor, groupMinor;
  assign groupMajor = groupBase + LOG_G'(slotMajor);
  assign groupMinor = groupBase + LOG_G'(slotMinor);

  logic [LOG_G-1:0] groupMajorRev;
  logic [LOG_C-1:0] innerMajorRev;

  for (genvar b = 0; b < LOG_C; b++) begin : g_rev
    assign groupMajorRev[b] = groupMajor[LOG_C-1-b];
    assign innerMajorRev[b] = innerMajor[LOG_C-1-b];
  end

  logic [LOG_N-1:0] offset;

  always_comb begin
    unique case (mode)
      XFER_TRANSPOSE: begin
        offset     = {innerMinor, groupMinor};
        bufAddr    = {slotMinor, innerMinor};
        burstFirst = (slotMinor == '0);
        burstLen   = LEN_SLOTS;
      end
      XFER_TRANSPOSE_REV: begin
        offset     = {groupMajorRev, innerMajor};
        bufAddr    = {slotMajor, innerMajorRev};
        burstFirst = (innerMajor == '0);
        burstLen   = LEN_GROUP;
      end
      default: begin
        offset     = {groupMajor, innerMajor};
        bufAddr    = cnt;
        burstFirst = (cnt == '0);
        burstLen   = LEN_ALL;
      end
    endcase
  end

  assign dramAddr = base + ADDR_W'(offset);

endmodule

// File: rtl/ntt_xfer_path.sv
module ntt_xfer_path
  import ntt_xfer_pkg::*;
#(
  parameter int LOG_N  = 12,
  parameter int LOG_K  = 3,
  parameter int ADDR_W = 32,
  localparam int LOG_C  = LOG_N / 2,
  localparam int LOG_G  = LOG_C,
  localparam int BEAT_W = LOG_K + LOG_C,
  localparam int LEN_W  = BEAT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [1:0]        cmdMode,
  input  logic [LOG_G-1:0]  cmdGroup,
  input  logic [ADDR_W-1:0] cmdBase,
  output logic              lastBeat,
  output logic [ADDR_W-1:0] dramAddr,
  output logic [BEAT_W-1:0] bufAddr,
  output logic              burstFirst,
  output logic [LEN_W-1:0]  burstLen
);

  xferMode_t         modeQ;
  logic [LOG_G-1:0]  groupQ;
  logic [ADDR_W-1:0] baseQ;
  logic [BEAT_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= XFER_LINEAR;
      groupQ <= '0;
      baseQ  <= '0;
      cntQ   <= '0;
    end else if (strobes.load) begin
      modeQ  <= xferMode_t'(cmdMode);
      groupQ <= cmdGroup;
      baseQ  <= cmdBase;
      cntQ   <= '0;
    end else if (strobes.step) begin
      cntQ   <= cntQ + BEAT_W'(1);
    end
  end

  assign lastBeat = &cntQ;

  ntt_xfer_perm #(
    .LOG_N (LOG_N),
    .LOG_K (LOG_K),
    .ADDR_W(ADDR_W)
  ) i_perm (
    .mode      (modeQ),
    .cnt       (cntQ),
    .groupBase (groupQ),
    .base      (baseQ),
    .dramAddr  (dramAddr),
    .bufAddr   (bufAddr),
    .burstFirst(burstFirst),
    .burstLen  (burstLen)
  );

endmodule

// File: rtl/ntt_xfer_agu.sv
module ntt_xfer_agu
  import ntt_xfer_pkg::*;
#(
  parameter int LOG_N  = 12,
  parameter int LOG_K  = 3,
  parameter int ADDR_W = 32,
  localparam int LOG_C  = LOG_N / 2,
  localparam int BEAT_W = LOG_K + LOG_C,
  localparam int LEN_W  = BEAT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        cmdMode,
  input  logic [LOG_C-1:0]  cmdGroup,
  input  logic [ADDR_W-1:0] cmdBase,
  output logic              busy,
  output logic              done,
  output logic              beatValid,
  output logic [ADDR_W-1:0] dramAddr,
  output logic [BEAT_W-1:0] bufAddr,
  output logic              burstStart,
  output logic [LEN_W-1:0]  burstLen
);

  ctrlStrobes_t strobes;
  logic         lastBeat;
  logic         burstFirst;

  ntt_xfer_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .lastBeat (lastBeat),
    .strobes  (strobes),
    .busy     (busy),
    .beatValid(beatValid),
    .done     (done)
  );

  ntt_xfer_path #(
    .LOG_N (LOG_N),
    .LOG_K (LOG_K),
    .ADDR_W(ADDR_W)
  ) i_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .cmdMode   (cmdMode),
    .cmdGroup  (cmdGroup),
    .cmdBase   (cmdBase),
    .lastBeat  (lastBeat),
    .dramAddr  (dramAddr),
    .bufAddr   (bufAddr),
    .burstFirst(burstFirst),
    .burstLen  (burstLen)
  );

  assign burstStart = beatValid & burstFirst;

endmodule

// File: rtl/ntt_xfer_agu_chk.sv
module ntt_xfer_agu_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              beatValid,
  input logic [ADDR_W-1:0] dramAddr,
  input logic              burstStart,
  input logic [LEN_W-1:0]  burstLen
);

  logic             inBurst;
  logic [LEN_W-1:0] beatCount;
  logic [LEN_W-1:0] lenHeld;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inBurst   <= 1'b0;
      beatCount <= '0;
      lenHeld   <= '0;
    end else if (beatValid && burstStart) begin
      inBurst   <= 1'b1;
      beatCount <= LEN_W'(1);
      lenHeld   <= burstLen;
    end else if (beatValid) begin
      beatCount <= beatCount + LEN_W'(1);
    end else begin
      inBurst   <= 1'b0;
    end
  end

  assert_busy_needs_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!beatValid && !busy));

  assert_busy_ends_in_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));

  assert_first_beat_opens_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(beatValid) |-> burstStart);

  assert_burst_ascending_R8: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && !burstStart) |-> (dramAddr == $past(dramAddr) + ADDR_W'(1)));

  assert_burst_len_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && !burstStart) |-> $stable(burstLen));

  assert_burst_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inBurst && (burstStart || !beatValid)) |-> (beatCount == lenHeld));

endmodule

bind ntt_xfer_agu ntt_xfer_agu_chk #(
  .ADDR_W(ADDR_W),
  .LEN_W (LEN_W)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .beatValid (beatValid),
  .dramAddr  (dramAddr),
  .burstStart(burstStart),
  .burstLen  (burstLen)
);

// File: tb/test_ntt_xfer_agu.sv
module test_ntt_xfer_agu;

  localparam int CLK_PERIOD = 10;
  localparam int LOG_N  = 6;
  localparam int LOG_K  = 2;
  localparam int ADDR_W = 16;
  localparam int N      = 64;
  localparam int C      = 8;
  localparam int G      = 8;
  localparam int K      = 4;
  localparam int BEATS  = K * C;
  localparam int WATCHDOG = 20000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [1:0]        cmdMode = '0;
  logic [2:0]        cmdGroup = '0;
  logic [ADDR_W-1:0] cmdBase = '0;
  logic              busy, done, beatValid, burstStart;
  logic [ADDR_W-1:0] dramAddr;
  logic [4:0]        bufAddr;
  logic [5:0]        burstLen;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int memVal [N];
  int memHits [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  ntt_xfer_agu #(.LOG_N(LOG_N), .LOG_K(LOG_K), .ADDR_W(ADDR_W)) i_ntt_xfer_agu (
    .clk(clk), .rstN(rstN), .start(start), .cmdMode(cmdMode),
    .cmdGroup(cmdGroup), .cmdBase(cmdBase), .busy(busy), .done(done),
    .beatValid(beatValid), .dramAddr(dramAddr), .bufAddr(bufAddr),
    .burstStart(burstStart), .burstLen(burstLen)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int rev3(input int v);
    return ((v & 1) << 2) | (v & 2) | ((v >> 2) & 1);
  endfunction

  function automatic int expDram(input int mode, input int g0, input int base, input int i);
    int off;
    case (mode)
      1:       off = (i / K) * G + ((g0 + i % K) % G);
      2:       off = rev3((g0 + i / C) % G) * C + (i % C);
      default: off = ((g0 + i / C) % G) * C + (i % C);
    endcase
    return (base + off) & 16'hFFFF;
  endfunction

  function automatic int expBuf(input int mode, input int i);
    case (mode)
      1:       return (i % K) * C + (i / K);
      2:       return (i / C) * C + rev3(i % C);
      default: return i;
    endcase
  endfunction

  function automatic bit expFirst(input int mode, input int i);
    case (mode)
      1:       return (i % K) == 0;
      2:       return (i % C) == 0;
      default: return i == 0;
    endcase
  endfunction

  function automatic int expLen(input int mode);
    case (mode)
      1:       return K;
      2:       return C;
      default: return BEATS;
    endcase
  endfunction

  function automatic string modeTag(input int mode);
    case (mode)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic runCmd(input int mode, input int g0, input int base,
                        input bit inject, input bit model);
    string tag;
    tag = inject ? "R3" : modeTag(mode);
    @(negedge clk);
    start = 1'b1; cmdMode = 2'(mode); cmdGroup = 3'(g0); cmdBase = ADDR_W'(base);
    @(negedge clk);
    start = inject;
    check(busy == 1'b1, "R2", "busy after start", busy, 1);
    for (int i = 0; i < BEATS; i++) begin
      if (i > 0) @(negedge clk);
      if (inject) begin
        cmdMode  = 2'($urandom);
        cmdGroup = 3'($urandom);
        cmdBase  = ADDR_W'($urandom);
        start    = (i < BEATS - 1);
      end
      check(beatValid == 1'b1, "R2", "beatValid during command", beatValid, 1);
      check(int'(dramAddr) == expDram(mode, g0, base, i), tag, "dramAddr",
            dramAddr, expDram(mode, g0, base, i));
      check(int'(bufAddr) == expBuf(mode, i), tag, "bufAddr", bufAddr, expBuf(mode, i));
      check(burstStart == expFirst(mode, i), "R8", "burstStart", burstStart, expFirst(mode, i));
      if (expFirst(mode, i))
        check(int'(burstLen) == expLen(mode), "R8", "burstLen", burstLen, expLen(mode));
      if (model) begin
        int idx;
        idx = (int'(dramAddr) - base) & 16'hFFFF;
        if (idx < N) begin
          memVal[idx] = g0 * C + int'(bufAddr);
          memHits[idx]++;
        end
      end
    end
    start = 1'b0;
    @(negedge clk);
    check(done == 1'b1, "R2", "done after last beat", done, 1);
    check(busy == 1'b0 && beatValid == 1'b0, "R2", "idle with done", busy, 0);
    @(negedge clk);
    check(done == 1'b0, "R2", "done single cycle", done, 0);
  endtask

  task automatic clearModel();
    for (int a = 0; a < N; a++) begin
      memVal[a] = -1;
      memHits[a] = 0;
    end
  endtask

  task automatic checkModel(input bit withRev);
    for (int g = 0; g < G; g++) begin
      for (int c = 0; c < C; c++) begin
        int dst;
        dst = withRev ? rev3(g) * C + rev3(c) : c * G + g;
        check(memHits[dst] == 1, "R9", "word written once", memHits[dst], 1);
        check(memVal[dst] == g * C + c, "R9", "word contents", memVal[dst], g * C + c);
      end
    end
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check(busy == 0 && beatValid == 0 && done == 0 && burstStart == 0,
          "R1", "outputs in reset", busy, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 0 && beatValid == 0 && done == 0 && burstStart == 0,
          "R1", "outputs idle after reset", beatValid, 0);

    // Directed corners for each mode, including wrap of the address space.
    runCmd(0, 0, 0, 0, 0);
    runCmd(1, 4, 16'h0100, 0, 0);
    runCmd(2, 4, 16'hFFF0, 0, 0);
    runCmd(3, 4, 16'hFFE8, 0, 0);
    runCmd(1, 0, 16'h1234, 1, 0);

    // Memory model: full epoch reordering in both reordering modes.
    clearModel();
    for (int b = 0; b < G / K; b++) runCmd(1, b * K, 16'h0200, 0, 1);
    checkModel(0);
    clearModel();
    for (int b = 0; b < G / K; b++) runCmd(2, b * K, 16'h0040, 0, 1);
    checkModel(1);

    // Random commands with occasional start/inputs toggling while busy.
    for (int r = 0; r < 40; r++) begin
      runCmd(int'($urandom % 4), int'(($urandom % (G / K)) * K),
             int'($urandom % 65536), ($urandom % 4) == 0, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule